// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block remaps bus addresses that fall inside a graphics aperture onto physical pages. The first translation level is an on-chip directory of 64 slots, each naming one memory page that holds 1024 second-level entries of 32 bits. Software loads a slot by writing one packed 32-bit word. The second level stays in system memory, and the block fetches a single word of it per translation over a simple request/response read port.

A lookup is accepted while `req_ready` is high. The block subtracts the aperture base from bus address bits 31:22 to get the directory slot, and uses bits 21:12 as the entry offset. It answers with a one-cycle `resp_valid` pulse carrying a hit flag and the translated address. Requests that are disabled, outside the aperture or aimed at an empty slot miss at once. A small fully associative cache of recent translations lets repeated pages skip the memory read. Writing the control word 0x2200 and then 0x2280 flushes that cache, and any directory write also clears it.

The controller has three states. IDLE accepts lookups and answers the quick cases itself. IDLE goes to ISSUE when a lookup needs memory. ISSUE holds the read request and goes to WAIT when `mem_req_ready` is seen. WAIT goes back to IDLE when `mem_rsp_valid` arrives.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_req_valid` is 0, all directory slots are empty, the cache is empty, and translation is disabled.
- R2: A directory write uses bits 5:0 as the slot number, bit 8 as present, and bits 31:12 as the page address of the second-level table. Bits 11:9 and 7:6 have no effect. A write with bit 8 clear empties the slot.
- R3: The slot is (bus address bits 31:22 − `ap_base`) modulo 1024, and the offset is bus address bits 21:12. A lookup is inside the aperture only if the slot is below the slot count for `ap_size`: code 0 gives 64, code 32 gives 32, code 48 gives 16, and any other code gives 8.
- R4: A memory read fetches one word at {slot page, offset, 2'b00}. `mem_req_valid` stays high with a stable address until `mem_req_ready` is sampled high. Exactly one read is made per lookup that needs memory.
- R5: A fetched entry with bit 0 set gives a hit, and `resp_paddr` = {entry bits 31:12, bus address bits 11:0}. An entry with bit 0 clear gives a miss.
- R6: A lookup that is disabled, outside the aperture, or aimed at an empty slot misses with no memory read. Every miss returns `resp_paddr` = 0.
- R7: Translation is enabled only while the most recent control word is 0x2280. A flush happens when a 0x2280 write directly follows a 0x2200 control write. Repeating 0x2280 does not flush.
- R8: Valid translations are kept in a 4-entry cache keyed by bus address bits 31:12, with round-robin replacement. A cache hit answers with no memory read. Entries with bit 0 clear are never cached. A flush or any directory write empties the cache.
- R9: A lookup answered without memory raises `resp_valid` in the cycle after acceptance, and `req_ready` stays high. A lookup that needs memory drops `req_ready` until its response, and the response comes one cycle after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dir_we | input | 1 | Directory write strobe |
| dir_wdata | input | 32 | Packed directory word |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word |
| ap_base | input | 10 | Aperture base, bus address bits 31:22 |
| ap_size | input | 8 | Aperture size code |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Bus address to translate |
| req_ready | output | 1 | Lookup can be accepted |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Translation found |
| resp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Word address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Second-level entry |

## Verification
Lookups are issued to present slots with valid entries, to entries with bit 0 clear, to empty slots, to addresses below the base, and to slots just inside and just past the limit of each size code. Comparing these cases separates hits, fetched misses and immediate misses. Counting memory reads tells cache hits apart from refetches. Sweeping five pages past a 4-entry cache shows the round-robin eviction. Separate control sequences (0x2200 then 0x2280, and 0x2280 repeated) and directory writes show when the cache is cleared and when it is not. A memory that holds off its ready shows that the request is held.

// File: rtl/apx_pkg.sv
package apx_pkg;
    localparam int ADDR_W = 32;
    localparam int PAGE_W = 20;
    localparam int OFF_W  = 10;
    localparam int TOP_W  = ADDR_W - PAGE_W - 2;

    localparam logic [31:0] CTL_ARM = 32'h0000_2200;
    localparam logic [31:0] CTL_RUN = 32'h0000_2280;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } apx_state_e;

    function automatic logic [6:0] slots_for_code(input logic [7:0] code);
        logic [6:0] n;
        case (code)
            8'd0:    n = 7'd64;
            8'd32:   n = 7'd32;
            8'd48:   n = 7'd16;
            default: n = 7'd8;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/apx_dir.sv
module apx_dir #(
    parameter int SLOTS = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [31:0]                wr_word,
    input  logic [$clog2(SLOTS)-1:0]   rd_slot,
    output logic                       rd_present,
    output logic [apx_pkg::PAGE_W-1:0] rd_page
);
    localparam int SW = $clog2(SLOTS);

    logic [SLOTS-1:0]           present_q;
    logic [apx_pkg::PAGE_W-1:0] page_q [SLOTS];
    logic [SW-1:0]              wr_slot;

    assign wr_slot = wr_word[SW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            present_q <= '0;
        else if (wr_en)
            present_q[wr_slot] <= wr_word[8];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            page_q[wr_slot] <= wr_word[31:12];
    end

    assign rd_present = present_q[rd_slot];
    assign rd_page    = page_q[rd_slot];
endmodule

// File: rtl/apx_tcache.sv
module apx_tcache #(
    parameter int ENTRIES = 4,
    parameter int KEY_W   = 20,
    parameter int VAL_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [KEY_W-1:0] look_key,
    output logic             hit,
    output logic [VAL_W-1:0] hit_val,
    input  logic             fill,
    input  logic [KEY_W-1:0] fill_key,
    input  logic [VAL_W-1:0] fill_val
);
    localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] match;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [VAL_W-1:0]   val_q [ENTRIES];
    logic [PW-1:0]      ptr_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid_q[i] && (key_q[i] == look_key);
    end

    always_comb begin
        hit_val = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) hit_val = hit_val | val_q[i];
    end
    assign hit = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (clr) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (fill) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill && !clr) begin
            key_q[ptr_q] <= fill_key;
            val_q[ptr_q] <= fill_val;
        end
    end

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_q == '0));
endmodule

// File: rtl/apx_ctl.sv
module apx_ctl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        enable,
    output logic        flush
);
    logic [31:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= '0;
        else if (we)
            last_q <= wdata;
    end

    assign enable = (last_q == apx_pkg::CTL_RUN);
    assign flush  = we && (wdata == apx_pkg::CTL_RUN) && (last_q == apx_pkg::CTL_ARM);

    assert_flush_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> enable);
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
    parameter int DIR_SLOTS     = 64,
    parameter int CACHE_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dir_we,
    input  logic [31:0] dir_wdata,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic [9:0]  ap_base,
    input  logic [7:0]  ap_size,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        resp_valid,
    output logic        resp_hit,
    output logic [31:0] resp_paddr,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    import apx_pkg::*;

    localparam int SW = $clog2(DIR_SLOTS);

    apx_state_e state_q, state_d;

    logic              enable, flush;
    logic [TOP_W-1:0]  slot_raw;
    logic              in_ap, accept, quick;
    logic              d_present;
    logic [PAGE_W-1:0] d_page;
    logic              c_hit;
    logic [PAGE_W-1:0] c_val;
    logic              fill;
    logic [PAGE_W-1:0] vpn_q;
    logic [11:0]       lo_q;
    logic [31:0]       ent_addr_q;

    apx_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .enable(enable), .flush(flush)
    );

    apx_dir #(.SLOTS(DIR_SLOTS)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(dir_we), .wr_word(dir_wdata),
        .rd_slot(slot_raw[SW-1:0]), .rd_present(d_present), .rd_page(d_page)
    );

    apx_tcache #(.ENTRIES(CACHE_ENTRIES), .KEY_W(PAGE_W), .VAL_W(PAGE_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .clr(flush || dir_we),
        .look_key(req_addr[31:12]), .hit(c_hit), .hit_val(c_val),
        .fill(fill), .fill_key(vpn_q), .fill_val(mem_rsp_data[31:12])
    );

    assign slot_raw = req_addr[31:22] - ap_base;
    assign in_ap    = slot_raw < {3'b000, slots_for_code(ap_size)};
    assign accept   = req_valid && (state_q == ST_IDLE);
    assign quick    = !enable || !in_ap || c_hit || !d_present;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        fill          = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (accept && !quick) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    fill    = mem_rsp_data[0];
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // response and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_paddr <= '0;
            vpn_q      <= '0;
            lo_q       <= '0;
            ent_addr_q <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && quick) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= enable && in_ap && c_hit;
                        resp_paddr <= (enable && in_ap && c_hit) ? {c_val, req_addr[11:0]} : '0;
                    end else if (accept) begin
                        vpn_q      <= req_addr[31:12];
                        lo_q       <= req_addr[11:0];
                        ent_addr_q <= {d_page, req_addr[21:12], 2'b00};
                    end
                end
                ST_ISSUE: ;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= mem_rsp_data[0];
                        resp_paddr <= mem_rsp_data[0] ? {mem_rsp_data[31:12], lo_q} : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req_addr = ent_addr_q;

    assert_hold_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
    assert_read_needs_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid && req_ready));
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_paddr == 32'h0));
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    assert_resp_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |=> resp_valid);
endmodule

// File: tb/aperture_xlate_tb.sv
`timescale 1ns/1ps
module aperture_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_we, ctl_we, req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] dir_wdata, ctl_wdata, req_addr, mem_rsp_data;
    logic [9:0]  ap_base;
    logic [7:0]  ap_size;
    logic        req_ready, resp_valid, resp_hit, mem_req_valid;
    logic [31:0] resp_paddr, mem_req_addr;

    int checks = 0, errors = 0, nreads = 0, hold = 0, cd = 0;
    bit done = 0;
    logic [31:0] rd_addr;

    logic [31:0] memw [logic [31:0]];
    bit          m_pres [64];
    logic [19:0] m_page [64];
    logic [19:0] cq_vpn [$];
    logic [19:0] cq_ppn [$];
    logic [31:0] m_ctl;

    always #4 clk = ~clk;

    aperture_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .dir_wdata(dir_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ap_base(ap_base), .ap_size(ap_size),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_paddr(resp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return memw.exists(a) ? memw[a] : 32'h0;
    endfunction

    // memory responder
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mem_rd(rd_addr);
                end
            end
            if (mem_req_ready) begin
                mem_req_ready = 0;
                cd = 2;
            end else if (mem_req_valid) begin
                if (hold > 0) hold--;
                else begin
                    mem_req_ready = 1;
                    nreads++;
                    rd_addr = mem_req_addr;
                end
            end
        end
    end

    task automatic dir_write(input logic [31:0] w);
        @(negedge clk); dir_we = 1; dir_wdata = w;
        @(negedge clk); dir_we = 0;
        m_pres[w[5:0]] = w[8];
        m_page[w[5:0]] = w[31:12];
        cq_vpn.delete(); cq_ppn.delete();
    endtask

    task automatic ctl_write(input logic [31:0] w);
        @(negedge clk); ctl_we = 1; ctl_wdata = w;
        @(negedge clk); ctl_we = 0;
        if (w == 32'h2280 && m_ctl == 32'h2200) begin
            cq_vpn.delete(); cq_ppn.delete();
        end
        m_ctl = w;
    endtask

    task automatic lookup(input logic [31:0] a, input string req);
        logic [9:0]  slot;
        int          nsl, rd0, n, ci;
        bit          eh, em;
        logic [31:0] ep, e;
        slot = a[31:22] - ap_base;
        nsl  = (ap_size == 0) ? 64 : (ap_size == 32) ? 32 : (ap_size == 48) ? 16 : 8;
        eh = 0; em = 0; ep = 0; ci = -1;
        for (int i = 0; i < cq_vpn.size(); i++) if (cq_vpn[i] == a[31:12]) ci = i;
        if (m_ctl != 32'h2280 || int'(slot) >= nsl) ;
        else if (ci >= 0) begin eh = 1; ep = {cq_ppn[ci], a[11:0]}; end
        else if (m_pres[slot[5:0]]) begin
            em = 1;
            e  = mem_rd({m_page[slot[5:0]], a[21:12], 2'b00});
            eh = e[0];
            ep = e[0] ? {e[31:12], a[11:0]} : 32'h0;
        end
        rd0 = nreads;
        @(negedge clk); req_valid = 1; req_addr = a;
        @(negedge clk); req_valid = 0;
        if (!em) check(resp_valid === 1'b1, req, "R9 next-cycle response", {31'b0, resp_valid}, 1);
        else     check(req_ready === 1'b0, req, "R9 stall while reading", {31'b0, req_ready}, 0);
        n = 0;
        while (resp_valid !== 1'b1 && n < 40) begin @(negedge clk); n++; end
        check(resp_valid === 1'b1 && resp_hit === eh, req, "hit flag", {31'b0, resp_hit}, {31'b0, eh});
        check(resp_paddr === ep, req, "paddr", resp_paddr, ep);
        check(nreads - rd0 == int'(em), req, "memory reads", nreads - rd0, int'(em));
        if (em && eh) begin
            cq_vpn.push_back(a[31:12]); cq_ppn.push_back(ep[31:12]);
            if (cq_vpn.size() > 4) begin void'(cq_vpn.pop_front()); void'(cq_ppn.pop_front()); end
        end
        @(negedge clk);
        check(resp_valid === 1'b0, req, "single pulse", {31'b0, resp_valid}, 0);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; dir_we = 0; ctl_we = 0; req_valid = 0;
        dir_wdata = 0; ctl_wdata = 0; req_addr = 0;
        ap_base = 10'h200; ap_size = 8'd0; m_ctl = 0;
        for (int i = 0; i < 64; i++) begin m_pres[i] = 0; m_page[i] = 0; end
        memw[32'h0012_300C] = 32'hCAFE_0001;
        memw[32'h0012_3010] = 32'h1234_5000;
        memw[32'h0045_6000] = 32'h0BEE_F001;
        memw[32'h00AB_C004] = 32'h7777_7001;
        memw[32'h0089_A000] = 32'h5555_5001;
        for (int k = 10; k < 15; k++) memw[32'h0012_3000 + 4*k] = 32'h0010_0001 + (k << 12);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1", "req_ready in reset", {31'b0, req_ready}, 1);
        check(resp_valid === 1'b0, "R1", "resp_valid in reset", {31'b0, resp_valid}, 0);
        check(mem_req_valid === 1'b0, "R1", "mem_req_valid in reset", {31'b0, mem_req_valid}, 0);
        rst_n = 1;
        @(negedge clk);
        dir_write(32'h0012_3100);            // R2 slot 0
        lookup(32'h8000_3ABC, "R1/R7");      // disabled: miss, no read
        ctl_write(32'h2280);
        dir_write(32'h0045_6F05);            // R2 attribute bits ignored, slot 5
        dir_write(32'h00AB_C13F);            // slot 63
        dir_write(32'h0089_A11F);            // slot 31
        lookup(32'h8000_3ABC, "R5");         // fetched hit
        lookup(32'h8000_3ABC, "R8");         // cache hit
        lookup(32'h8000_4000, "R5");         // bit 0 clear
        lookup(32'h8000_4000, "R8");         // not cached, read again
        lookup(32'h8140_0010, "R2");
        lookup(32'h81C0_0000, "R6");         // empty slot 7
        lookup(32'h7FC0_0000, "R3");         // below base
        lookup(32'h8FC0_1234, "R3");         // last slot of 64
        hold = 3;
        lookup(32'h87C0_0000, "R4");         // slot 31 with held ready
        ap_size = 8'd32;
        lookup(32'h87C0_0000, "R3");         // slot 31 inside 32
        lookup(32'h8FC0_1234, "R3");         // slot 63 outside 32
        ap_size = 8'd48;
        lookup(32'h87C0_0000, "R3");         // slot 31 outside 16
        ap_size = 8'd56;
        lookup(32'h8140_0010, "R3");         // slot 5 inside 8
        ap_size = 8'd5;
        lookup(32'h8140_0010, "R3");         // unknown code, 8 slots
        ap_size = 8'd0;
        ctl_write(32'h2200);
        lookup(32'h8000_3ABC, "R7");         // disabled by 0x2200
        ctl_write(32'h2280);                 // flush
        lookup(32'h8000_3ABC, "R7");         // refetched
        ctl_write(32'h2280);                 // no flush
        lookup(32'h8000_3ABC, "R7");         // still cached
        for (int k = 10; k < 15; k++) lookup(32'h8000_0000 + (k << 12), "R8");
        lookup(32'h8000_3ABC, "R8");         // evicted round robin
        lookup(32'h8000_E000, "R8");         // newest still cached
        dir_write(32'h0000_0108);            // unrelated slot write clears cache
        lookup(32'h8000_E000, "R8");
        dir_write(32'h0000_0005);            // R2 present clear empties slot 5
        lookup(32'h8140_0010, "R2");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule